// File: doc/BRIEF.md
# Microcode Instruction Dispatch Modifier

This block belongs to the instruction-emulation task of a 16-bit horizontally microcoded processor. It holds the emulated instruction register and a sticky skip flag. Each microinstruction it forms a small value that the microsequencer ORs into the low bits of its next address. Which value it forms depends on a one-hot set of strobes decoded from the microinstruction: load the instruction register, 16-way instruction dispatch, accumulator-source table dispatch, and bus-odd merge. A separate strobe sets the skip flag.

Bit numbering in this document is big-endian: word bit 0 is the most significant bit. In the RTL, bit 0 corresponds to `[15]`. The accumulator-source dispatch reads a 256-entry table indexed by the instruction's upper byte. The table is written through a port that works only while reset is asserted. The modifier is registered. It is valid for the one cycle after the strobe that formed it, and it returns to zero in the next cycle unless another strobe forms a new value.

Top module: `udisp_modifier`

## Requirements
- R1: While reset is low, the instruction register, the skip flag and the modifier are all zero.
- R2: On the load strobe, the bus is captured into the instruction register. On the following cycle the modifier is {BUS[0], BUS[5..7]}, with BUS[0] at modifier bit 3. The instruction register changes only on the load strobe.
- R3: The load strobe clears the skip flag. This clear wins over a skip-set strobe in the same cycle.
- R4: The skip-set strobe sets the skip flag. The flag then stays set until a load strobe or reset.
- R5: 16-way dispatch, first two tests in priority order. If IR[0]=1, the modifier is 3 minus IR[8..9]. Otherwise, if IR[1..2]=0, the modifier is IR[3..4].
- R6: 16-way dispatch with IR[0]=0: IR[1..2]=1 gives 4, and IR[1..2]=2 gives 5.
- R7: 16-way dispatch with IR[0..2]=011: IR[4..7] is remapped 0→1, 1→0, 6→14 and 14→6. Every other value passes through unchanged.
- R8: The table dispatch sets the modifier to the low four bits of the table entry indexed by IR[0..7].
- R9: The bus-odd strobe ORs BUS[15] (the least significant bus bit) into modifier bit 0.
- R10: In a cycle with no dispatch strobe, the modifier that follows is zero.
- R11: A dispatch in the cycle right after a load uses the newly loaded instruction.
- R12: Table writes made while reset is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the table write port is active only while this is low |
| bus_i | input | 16 | Processor bus |
| f_load_ir | input | 1 | Load-instruction strobe |
| f_idisp | input | 1 | 16-way instruction dispatch strobe |
| f_acsrc | input | 1 | Table dispatch strobe |
| f_busodd | input | 1 | Bus-odd merge strobe |
| f_skip_set | input | 1 | Skip-set strobe |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write index |
| tbl_data | input | 8 | Table write data |
| mod_o | output | 4 | Next-address modifier |
| ir_o | output | 16 | Instruction register copy |
| skip_o | output | 1 | Skip flag |

## Verification
The assertions assume that at most one of the four dispatch strobes (load, 16-way, table, bus-odd) is high in any cycle, as happens when they come from one microinstruction field. The skip-set strobe may coincide with any of them. The stimulus chooses at most one dispatch strobe per cycle and toggles skip-set on its own. The table is programmed in full before reset is released, so no dispatch ever reads an unwritten entry.

// File: rtl/udisp_pkg.sv
package udisp_pkg;
  localparam int WORD_W = 16;
  localparam int MOD_W  = 4;

  // Modifier merged on instruction load: word bit0 -> mod[3], bits5..7 -> mod[2:0]
  function automatic logic [MOD_W-1:0] load_merge(input logic [WORD_W-1:0] b);
    return {b[15], b[10:8]};
  endfunction

  // Priority decode for the 16-way instruction dispatch
  function automatic logic [MOD_W-1:0] idisp_code(input logic [WORD_W-1:0] ir);
    logic [MOD_W-1:0] r;
    if (ir[15]) begin
      r = 4'd3 - {2'b00, ir[7:6]};
    end else begin
      case (ir[14:13])
        2'd0: r = {2'b00, ir[12:11]};
        2'd1: r = 4'd4;
        2'd2: r = 4'd5;
        default: begin
          case (ir[11:8])
            4'd0:    r = 4'd1;
            4'd1:    r = 4'd0;
            4'd6:    r = 4'd14;
            4'd14:   r = 4'd6;
            default: r = ir[11:8];
          endcase
        end
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/udisp_ir_state.sv
module udisp_ir_state #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              skip_set_evt,
  input  logic [WORD_W-1:0] bus,
  output logic [WORD_W-1:0] ir_q,
  output logic              skip_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      if (load_evt) ir_q <= bus;
      if (load_evt)          skip_q <= 1'b0;
      else if (skip_set_evt) skip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/udisp_lut.sv
module udisp_lut #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [OUT_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign wr_ok = we && !rst_n;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr][OUT_W-1:0];
endmodule

// File: rtl/udisp_modgen.sv
module udisp_modgen
  import udisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              idisp_evt,
  input  logic              acsrc_evt,
  input  logic              busodd_evt,
  input  logic [WORD_W-1:0] bus,
  input  logic [WORD_W-1:0] ir,
  input  logic [MOD_W-1:0]  lut_val,
  output logic [MOD_W-1:0]  mod_q
);
  logic [MOD_W-1:0] base_d;
  logic [MOD_W-1:0] mod_d;

  always_comb begin
    base_d = '0;
    if (load_evt)       base_d = load_merge(bus);
    else if (idisp_evt) base_d = idisp_code(ir);
    else if (acsrc_evt) base_d = lut_val;
    mod_d = base_d | {{(MOD_W-1){1'b0}}, busodd_evt & bus[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= '0;
    else        mod_q <= mod_d;
  end
endmodule

// File: rtl/udisp_modifier.sv
module udisp_modifier
  import udisp_pkg::*;
#(
  parameter int LUT_AW = 8,
  parameter int LUT_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_i,
  input  logic              f_load_ir,
  input  logic              f_idisp,
  input  logic              f_acsrc,
  input  logic              f_busodd,
  input  logic              f_skip_set,
  input  logic              tbl_we,
  input  logic [LUT_AW-1:0] tbl_addr,
  input  logic [LUT_DW-1:0] tbl_data,
  output logic [3:0]        mod_o,
  output logic [15:0]       ir_o,
  output logic              skip_o
);
  // named internal events
  logic              load_evt, idisp_evt, acsrc_evt, busodd_evt, skip_set_evt;
  logic [WORD_W-1:0] ir_q;
  logic [MOD_W-1:0]  lut_val;

  assign load_evt     = f_load_ir;
  assign idisp_evt    = f_idisp;
  assign acsrc_evt    = f_acsrc;
  assign busodd_evt   = f_busodd;
  assign skip_set_evt = f_skip_set;

  udisp_ir_state #(.WORD_W(WORD_W)) u_state (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .skip_set_evt(skip_set_evt),
    .bus(bus_i), .ir_q(ir_q), .skip_q(skip_o)
  );

  udisp_lut #(.AW(LUT_AW), .DW(LUT_DW), .OUT_W(MOD_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(ir_q[WORD_W-1 -: LUT_AW]), .rdata(lut_val)
  );

  udisp_modgen u_gen (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .idisp_evt(idisp_evt),
    .acsrc_evt(acsrc_evt), .busodd_evt(busodd_evt), .bus(bus_i), .ir(ir_q),
    .lut_val(lut_val), .mod_q(mod_o)
  );

  assign ir_o = ir_q;
endmodule

// File: rtl/udisp_chk.sv
module udisp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_i,
  input logic        f_load_ir,
  input logic        f_idisp,
  input logic        f_acsrc,
  input logic        f_busodd,
  input logic        f_skip_set,
  input logic [3:0]  mod_o,
  input logic [15:0] ir_o,
  input logic        skip_o
);
  logic any_disp;
  assign any_disp = f_load_ir | f_idisp | f_acsrc | f_busodd;

  a_r2_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    f_load_ir |=> ir_o == $past(bus_i));
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !f_load_ir |=> $stable(ir_o));
  a_r2_load_merge: assert property (@(posedge clk) disable iff (!rst_n)
    f_load_ir && !f_busodd |=> mod_o == {$past(bus_i[15]), $past(bus_i[10:8])});
  a_r3_load_clears_skip: assert property (@(posedge clk) disable iff (!rst_n)
    f_load_ir |=> !skip_o);
  a_r4_skip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    f_skip_set && !f_load_ir |=> skip_o);
  a_r4_skip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o && !f_load_ir |=> skip_o);
  a_r6_lda_code: assert property (@(posedge clk) disable iff (!rst_n)
    f_idisp && !f_load_ir && !f_busodd && ir_o[15:13] == 3'b001 |=> mod_o == 4'd4);
  a_r6_sta_code: assert property (@(posedge clk) disable iff (!rst_n)
    f_idisp && !f_load_ir && !f_busodd && ir_o[15:13] == 3'b010 |=> mod_o == 4'd5);
  a_r9_busodd_alone: assert property (@(posedge clk) disable iff (!rst_n)
    f_busodd && !f_load_ir && !f_idisp && !f_acsrc |=> mod_o == {3'b000, $past(bus_i[0])});
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !any_disp |=> mod_o == 4'd0);
endmodule

bind udisp_modifier udisp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .f_load_ir(f_load_ir), .f_idisp(f_idisp),
  .f_acsrc(f_acsrc), .f_busodd(f_busodd), .f_skip_set(f_skip_set),
  .mod_o(mod_o), .ir_o(ir_o), .skip_o(skip_o)
);

// File: tb/udisp_modifier_bench.sv
module udisp_modifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_i = '0;
  logic        f_load_ir = 0, f_idisp = 0, f_acsrc = 0, f_busodd = 0, f_skip_set = 0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_addr = '0, tbl_data = '0;
  logic [3:0]  mod_o;
  logic [15:0] ir_o;
  logic        skip_o;

  int n_tests = 0, n_fail = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  int ir_m = 0, skip_m = 0, mod_m = 0;
  int tbl_m [256];

  always #2 clk = ~clk;

  udisp_modifier u_udisp_modifier (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .f_load_ir(f_load_ir), .f_idisp(f_idisp),
    .f_acsrc(f_acsrc), .f_busodd(f_busodd), .f_skip_set(f_skip_set), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .mod_o(mod_o), .ir_o(ir_o), .skip_o(skip_o)
  );

  // big-endian field: bits [first..last] of a 16-bit word, bit 0 = MSB
  function automatic int fld(int w, int first, int last);
    return (w >> (15 - last)) & ((1 << (last - first + 1)) - 1);
  endfunction

  function automatic int disp16(int w);
    int grp, low;
    if (fld(w, 0, 0) == 1) return 3 - fld(w, 8, 9);
    grp = fld(w, 1, 2);
    if (grp == 0) return fld(w, 3, 4);
    if (grp == 1) return 4;
    if (grp == 2) return 5;
    low = fld(w, 4, 7);
    if (low == 0) return 1;
    if (low == 1) return 0;
    if (low == 6) return 14;
    if (low == 14) return 6;
    return low;
  endfunction

  always @(posedge clk) begin
    int b, nm;
    b = int'(bus_i);
    if (!rst_n) begin
      ir_m = 0; skip_m = 0; mod_m = 0;
      if (tbl_we) tbl_m[tbl_addr] = int'(tbl_data);
    end else begin
      nm = 0;
      if (f_load_ir)     nm = fld(b, 0, 0) * 8 + fld(b, 5, 7);
      else if (f_idisp)  nm = disp16(ir_m);
      else if (f_acsrc)  nm = tbl_m[fld(ir_m, 0, 7)] % 16;
      if (f_busodd)      nm = nm | fld(b, 15, 15);
      if (f_load_ir)       skip_m = 0;
      else if (f_skip_set) skip_m = 1;
      if (f_load_ir) ir_m = b;
      mod_m = nm;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("mod", int'(mod_o), mod_m);
      chk("ir", int'(ir_o), ir_m);
      chk("skip", int'(skip_o), skip_m);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(string t, logic [15:0] b, bit ld, bit id, bit ac, bit bo, bit ss);
    @(negedge clk);
    tag = t;
    bus_i = b; f_load_ir = ld; f_idisp = id; f_acsrc = ac; f_busodd = bo; f_skip_set = ss;
  endtask

  // load a word, then 16-way dispatch right after it (R11)
  task automatic ld_disp(string t, logic [15:0] w);
    step("R2", w, 1, 0, 0, 0, 0);
    step(t, 16'h0, 0, 1, 0, 0, 0);
    step("R10", 16'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tbl_m[i] = 0;
    // R1: program the table while reset is held
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tag = "R1";
      tbl_we = 1; tbl_addr = 8'(i); tbl_data = 8'((i * 37 + 11) & 255);
    end
    @(negedge clk); tbl_we = 0;
    @(negedge clk); rst_n = 1;
    // R2 / R11 / R5: IR[0]=1 forms, all four shift values
    for (int s = 0; s < 4; s++) ld_disp("R5", 16'h8000 | 16'(s << 6) | 16'h1234 & 16'h7f3f);
    // R5: IR[1..2]=0, IR[3..4] sweep
    for (int d = 0; d < 4; d++) ld_disp("R5", 16'(d << 11) | 16'h0455);
    // R6
    ld_disp("R6", 16'h2abc);
    ld_disp("R6", 16'h4f0f);
    // R7: every IR[4..7] value with IR[0..2]=011
    for (int k = 0; k < 16; k++) ld_disp("R7", 16'h6000 | 16'(k << 8) | 16'h0033);
    // R8: table dispatch after loads
    for (int k = 0; k < 8; k++) begin
      step("R2", 16'((k * 16'h2b01) ^ 16'h5a5a), 1, 0, 0, 0, 0);
      step("R8", 16'h0, 0, 0, 1, 0, 0);
    end
    // R12: write attempt outside reset has no effect on later table dispatch
    step("R12", 16'h3700, 1, 0, 0, 0, 0);
    @(negedge clk); tbl_we = 1; tbl_addr = 8'h37; tbl_data = 8'hff; f_load_ir = 0;
    @(negedge clk); tbl_we = 0;
    step("R12", 16'h0, 0, 0, 1, 0, 0);
    // R9: bus-odd alone, odd and even bus
    step("R9", 16'h0001, 0, 0, 0, 1, 0);
    step("R9", 16'hfffe, 0, 0, 0, 1, 0);
    step("R9", 16'h8003, 0, 0, 0, 1, 0);
    // R4 / R3: skip set, sticky, cleared by load, clear wins
    step("R4", 16'h0, 0, 0, 0, 0, 1);
    step("R4", 16'h0, 0, 0, 0, 0, 0);
    step("R4", 16'h0, 0, 1, 0, 0, 0);
    step("R3", 16'h1111, 1, 0, 0, 0, 0);
    step("R4", 16'h0, 0, 0, 0, 0, 1);
    step("R3", 16'h2222, 1, 0, 0, 0, 1);
    step("R10", 16'hffff, 0, 0, 0, 0, 0);
    // mixed random traffic, at most one dispatch strobe per cycle
    for (int n = 0; n < 600; n++) begin
      int pick;
      pick = $urandom_range(0, 5);
      step("R11", 16'($urandom), pick == 1, pick == 2, pick == 3, pick == 4,
           1'($urandom_range(0, 3) == 0));
    end
    step("R10", 16'h0, 0, 0, 0, 0, 0);
    // R1: reset again clears state
    @(negedge clk); tag = "R1"; rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule